// File: doc/BRIEF.md
# Processor Debug Halt Controller

This block sits beside a small processor core and decides when the core must stop normal execution and enter a debug state. It watches three break sources. The first is a bank of address comparators that are checked against each valid fetch address. The second is the set of interrupt requests, each gated by its own bit in a debug-enable mask. The third is an external stop request. When a break is taken, the controller holds the core halted until a debugger issues a resume command.

While the core is halted, the controller removes permission for memory fetch and drives a freeze output that peripherals use to stop their counters. It also records which source caused the break. A one-entry instruction holding register accepts words from the debugger and hands them to the core one at a time over a valid/ready handshake. Interrupts whose mask bit is clear are not breaks; they pass straight through to the core while it is running.

The finite state machine has two states. ST_RUN is normal execution. ST_HALT is the debug state. The transition ENTER goes from ST_RUN to ST_HALT when any break source fires. The transition LEAVE goes from ST_HALT to ST_RUN when resume is asserted.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset the controller is in ST_RUN with `freeze`=0, `fetch_en`=1, `insn_ready`=0, `core_insn_valid`=0 and `cause_kind`=0. The debug-enable mask resets to all zeros, so no interrupt causes a break until the mask is written.
- R2: In ST_RUN, if `fetch_valid`=1 and `fetch_addr` equals the address of an armed comparator, the controller is halted in the next cycle. A disarmed comparator, or a fetch with `fetch_valid`=0, causes no break.
- R3: An interrupt request whose debug-enable bit is 1 halts the controller in the next cycle. While the controller is running, requests whose enable bit is 0 appear on `irq_to_core` in the same cycle. While it is halted, `irq_to_core` is all zeros.
- R4: In ST_RUN, `ext_stop`=1 halts the controller in the next cycle.
- R5: In every cycle spent in ST_HALT, `freeze`=1, `halted`=1 and `fetch_en`=0.
- R6: When a break is taken, the cause is captured in `cause_kind` and `cause_idx`. The encoding of `cause_kind` is 3 for external, 1 for comparator and 2 for interrupt. For a comparator, `cause_idx` is the lowest matching comparator index; for an interrupt, it is the lowest enabled pending request index. If several sources fire in the same cycle, external wins over comparator, and comparator wins over interrupt.
- R7: Once captured, the cause stays unchanged until resume. Break sources that arrive while halted have no effect.
- R8: `insn_ready` is 1 only when halted with the holding register empty. An accepted word is shown on `core_insn_data` with `core_insn_valid`=1 and held stable until `core_insn_ready`=1. It is issued exactly once, after which the register is empty.
- R9: When `resume`=1 in ST_HALT, the next cycle is ST_RUN with `freeze`=0, `fetch_en`=1 and `cause_kind`=0. The holding register is flushed. A core handshake made in the resume cycle still completes, and a debugger word offered in that cycle is discarded.
- R10: `resume` in ST_RUN has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Core is presenting a fetch address |
| fetch_addr | input | ADDR_W | Current fetch address |
| bp_wr_en | input | 1 | Write one comparator |
| bp_wr_idx | input | clog2(NUM_BP) | Comparator selected for writing |
| bp_wr_addr | input | ADDR_W | Breakpoint address to load |
| bp_wr_arm | input | 1 | Arm bit to load with the address |
| den_wr_en | input | 1 | Write the debug-enable mask |
| den_wr_data | input | NUM_IRQ | New debug-enable mask |
| irq_req | input | NUM_IRQ | Interrupt requests |
| ext_stop | input | 1 | External stop request |
| resume | input | 1 | Debugger resume command |
| insn_valid | input | 1 | Debugger offers an instruction word |
| insn_data | input | INSN_W | Instruction word from the debugger |
| insn_ready | output | 1 | Holding register can accept a word |
| core_insn_valid | output | 1 | Injected word available to the core |
| core_insn_data | output | INSN_W | Injected word |
| core_insn_ready | input | 1 | Core takes the injected word |
| irq_to_core | output | NUM_IRQ | Interrupts passed on for normal handling |
| fetch_en | output | 1 | Memory fetch permitted |
| freeze | output | 1 | Peripheral freeze |
| halted | output | 1 | Controller is in the debug state |
| cause_kind | output | 2 | Source of the current break |
| cause_idx | output | max(clog2(NUM_BP), clog2(NUM_IRQ)) | Comparator or interrupt index of the break |

## Verification
Two pairs of events can fall in the same cycle. The first is several break sources firing together. The table-driven part of the bench raises an external stop, a comparator match and an enabled interrupt in one cycle in various combinations, then judges the captured cause against the priority order. The second is a resume command arriving together with an instruction handshake. The bench holds `core_insn_ready` and `resume` high in the same cycle. It confirms that the word was visible during that cycle, and that on the next cycle the controller runs with an empty holding register and a cleared cause. A second case resumes with a word still pending and shows that the word is gone after the next halt.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } dbg_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_BP   = 2'd1,
        CAUSE_IRQ  = 2'd2,
        CAUSE_EXT  = 2'd3
    } dbg_cause_e;

endpackage

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit #(
    parameter int NUM_BP = 4,
    parameter int ADDR_W = 32,
    localparam int IW    = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_arm,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              hit,
    output logic [IW-1:0]     hit_idx
);

    logic [NUM_BP-1:0] match;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        logic [ADDR_W-1:0] addr_q;
        logic              arm_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q <= '0;
                arm_q  <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                addr_q <= wr_addr;
                arm_q  <= wr_arm;
            end
        end

        assign match[g] = arm_q && fetch_valid && (fetch_addr == addr_q);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = NUM_BP - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/dbg_irq_filter.sv
module dbg_irq_filter #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               running,
    input  logic               den_wr_en,
    input  logic [NUM_IRQ-1:0] den_wr_data,
    input  logic [NUM_IRQ-1:0] irq_req,
    output logic [NUM_IRQ-1:0] irq_brk,
    output logic [NUM_IRQ-1:0] irq_pass
);

    logic [NUM_IRQ-1:0] den_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         den_q <= '0;
        else if (den_wr_en) den_q <= den_wr_data;
    end

    assign irq_brk  = irq_req & den_q;
    assign irq_pass = running ? (irq_req & ~den_q) : '0;

endmodule

// File: rtl/dbg_src_arb.sv
module dbg_src_arb
    import dbg_halt_pkg::*;
#(
    parameter int NUM_BP  = 4,
    parameter int NUM_IRQ = 8,
    localparam int BP_IW  = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
    localparam int IRQ_IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int OUT_IW = (BP_IW > IRQ_IW) ? BP_IW : IRQ_IW
) (
    input  logic               ext_stop,
    input  logic               bp_hit,
    input  logic [BP_IW-1:0]   bp_idx,
    input  logic [NUM_IRQ-1:0] irq_brk,
    output logic               brk,
    output dbg_cause_e         kind,
    output logic [OUT_IW-1:0]  idx
);

    logic [IRQ_IW-1:0] irq_idx;

    always_comb begin
        irq_idx = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (irq_brk[i]) irq_idx = IRQ_IW'(i);
        end
    end

    always_comb begin
        kind = CAUSE_NONE;
        idx  = '0;
        if (ext_stop) begin
            kind = CAUSE_EXT;
        end else if (bp_hit) begin
            kind = CAUSE_BP;
            idx  = OUT_IW'(bp_idx);
        end else if (|irq_brk) begin
            kind = CAUSE_IRQ;
            idx  = OUT_IW'(irq_idx);
        end
    end

    assign brk = (kind != CAUSE_NONE);

endmodule

// File: rtl/dbg_insn_buf.sv
module dbg_insn_buf #(
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_data,
    input  logic              out_ready
);

    logic              full_q;
    logic [INSN_W-1:0] data_q;

    assign in_ready  = enable && !full_q;
    assign out_valid = enable && full_q;
    assign out_data  = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (flush) begin
            full_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            full_q <= 1'b1;
            data_q <= in_data;
        end else if (out_valid && out_ready) begin
            full_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int NUM_BP  = 4,
    parameter int ADDR_W  = 32,
    parameter int NUM_IRQ = 8,
    parameter int INSN_W  = 32,
    localparam int BP_IW  = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
    localparam int IRQ_IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int CIW    = (BP_IW > IRQ_IW) ? BP_IW : IRQ_IW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic               bp_wr_en,
    input  logic [BP_IW-1:0]   bp_wr_idx,
    input  logic [ADDR_W-1:0]  bp_wr_addr,
    input  logic               bp_wr_arm,
    input  logic               den_wr_en,
    input  logic [NUM_IRQ-1:0] den_wr_data,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               ext_stop,
    input  logic               resume,
    input  logic               insn_valid,
    input  logic [INSN_W-1:0]  insn_data,
    output logic               insn_ready,
    output logic               core_insn_valid,
    output logic [INSN_W-1:0]  core_insn_data,
    input  logic               core_insn_ready,
    output logic [NUM_IRQ-1:0] irq_to_core,
    output logic               fetch_en,
    output logic               freeze,
    output logic               halted,
    output logic [1:0]         cause_kind,
    output logic [CIW-1:0]     cause_idx
);

    dbg_state_e         state_q, state_d;
    dbg_cause_e         kind_q, arb_kind;
    logic [CIW-1:0]     idx_q, arb_idx;
    logic               bp_hit, brk;
    logic [BP_IW-1:0]   bp_idx;
    logic [NUM_IRQ-1:0] irq_brk;
    logic               in_run, enter, leave;

    assign in_run = (state_q == ST_RUN);
    assign enter  = in_run && brk;
    assign leave  = !in_run && resume;

    dbg_bp_unit #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) u_bp (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bp_wr_en),
        .wr_idx      (bp_wr_idx),
        .wr_addr     (bp_wr_addr),
        .wr_arm      (bp_wr_arm),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .hit         (bp_hit),
        .hit_idx     (bp_idx)
    );

    dbg_irq_filter #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .running     (in_run),
        .den_wr_en   (den_wr_en),
        .den_wr_data (den_wr_data),
        .irq_req     (irq_req),
        .irq_brk     (irq_brk),
        .irq_pass    (irq_to_core)
    );

    dbg_src_arb #(.NUM_BP(NUM_BP), .NUM_IRQ(NUM_IRQ)) u_arb (
        .ext_stop (ext_stop),
        .bp_hit   (bp_hit),
        .bp_idx   (bp_idx),
        .irq_brk  (irq_brk),
        .brk      (brk),
        .kind     (arb_kind),
        .idx      (arb_idx)
    );

    dbg_insn_buf #(.INSN_W(INSN_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!in_run),
        .flush     (leave),
        .in_valid  (insn_valid),
        .in_data   (insn_data),
        .in_ready  (insn_ready),
        .out_valid (core_insn_valid),
        .out_data  (core_insn_data),
        .out_ready (core_insn_ready)
    );

    // next-state logic: ENTER and LEAVE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (brk)    state_d = ST_HALT;
            ST_HALT: if (resume) state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            kind_q  <= CAUSE_NONE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (enter) begin
                kind_q <= arb_kind;
                idx_q  <= arb_idx;
            end else if (leave) begin
                kind_q <= CAUSE_NONE;
                idx_q  <= '0;
            end
        end
    end

    always_comb begin
        halted   = 1'b0;
        freeze   = 1'b0;
        fetch_en = 1'b1;
        unique case (state_q)
            ST_RUN: ;
            ST_HALT: begin
                halted   = 1'b1;
                freeze   = 1'b1;
                fetch_en = 1'b0;
            end
        endcase
    end

    assign cause_kind = kind_q;
    assign cause_idx  = idx_q;

endmodule

// File: rtl/dbg_halt_chk.sv
module dbg_halt_chk #(
    parameter int NUM_IRQ = 8,
    parameter int INSN_W  = 32,
    parameter int CIW     = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ext_stop,
    input logic               resume,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic [NUM_IRQ-1:0] irq_to_core,
    input logic               core_insn_valid,
    input logic               core_insn_ready,
    input logic [INSN_W-1:0]  core_insn_data,
    input logic               insn_ready,
    input logic               fetch_en,
    input logic               freeze,
    input logic               halted,
    input logic [1:0]         cause_kind,
    input logic [CIW-1:0]     cause_idx
);

    // R4
    ext_stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && ext_stop) |=> (halted && cause_kind == 2'd3));

    // R5
    halt_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> (freeze && !fetch_en));

    // R7
    cause_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !resume) |=> ($stable(cause_kind) && $stable(cause_idx) && halted));

    // R8
    insn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_insn_valid && !core_insn_ready && !resume) |=>
            (core_insn_valid && $stable(core_insn_data)));

    // R8
    insn_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_insn_valid && core_insn_ready) |=> !core_insn_valid);

    // R8
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(insn_ready && core_insn_valid));

    // R9
    resume_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && resume) |=> (!freeze && fetch_en && cause_kind == 2'd0 && !core_insn_valid));

    // R3
    irq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted || ((irq_to_core & ~irq_req) == '0));

endmodule

bind dbg_halt_ctrl dbg_halt_chk #(.NUM_IRQ(NUM_IRQ), .INSN_W(INSN_W), .CIW(CIW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ext_stop        (ext_stop),
    .resume          (resume),
    .irq_req         (irq_req),
    .irq_to_core     (irq_to_core),
    .core_insn_valid (core_insn_valid),
    .core_insn_ready (core_insn_ready),
    .core_insn_data  (core_insn_data),
    .insn_ready      (insn_ready),
    .fetch_en        (fetch_en),
    .freeze          (freeze),
    .halted          (halted),
    .cause_kind      (cause_kind),
    .cause_idx       (cause_idx)
);

// File: tb/sim_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_halt_ctrl;

    typedef struct packed {
        logic       ext;
        logic [7:0] irq;
        logic [7:0] den;
        logic [2:0] sel;
        logic       halt;
        logic [1:0] kind;
        logic [2:0] idx;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 8'h00, 3'd4, 1'b0, 2'd0, 3'd0},
        '{1'b0, 8'h00, 8'h00, 3'd0, 1'b1, 2'd1, 3'd0},
        '{1'b0, 8'h00, 8'h00, 3'd2, 1'b1, 2'd1, 3'd2},
        '{1'b0, 8'h00, 8'h00, 3'd3, 1'b0, 2'd0, 3'd0},
        '{1'b0, 8'h04, 8'h00, 3'd4, 1'b0, 2'd0, 3'd0},
        '{1'b0, 8'h04, 8'h04, 3'd4, 1'b1, 2'd2, 3'd2},
        '{1'b0, 8'h90, 8'h80, 3'd4, 1'b1, 2'd2, 3'd7},
        '{1'b0, 8'h18, 8'h18, 3'd4, 1'b1, 2'd2, 3'd3},
        '{1'b1, 8'h00, 8'h00, 3'd4, 1'b1, 2'd3, 3'd0},
        '{1'b1, 8'h01, 8'h01, 3'd1, 1'b1, 2'd3, 3'd0},
        '{1'b0, 8'h01, 8'h01, 3'd1, 1'b1, 2'd1, 3'd1},
        '{1'b0, 8'h40, 8'hBF, 3'd4, 1'b0, 2'd0, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        bp_wr_en = 1'b0;
    logic [1:0]  bp_wr_idx = '0;
    logic [31:0] bp_wr_addr = '0;
    logic        bp_wr_arm = 1'b0;
    logic        den_wr_en = 1'b0;
    logic [7:0]  den_wr_data = '0;
    logic [7:0]  irq_req = '0;
    logic        ext_stop = 1'b0;
    logic        resume = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_data = '0;
    logic        insn_ready;
    logic        core_insn_valid;
    logic [31:0] core_insn_data;
    logic        core_insn_ready = 1'b0;
    logic [7:0]  irq_to_core;
    logic        fetch_en, freeze, halted;
    logic [1:0]  cause_kind;
    logic [2:0]  cause_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_halt_ctrl u0 (.*);

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [31:0] bp_addr(int s);
        return (s < 4) ? 32'h1000 * (s + 1) : 32'h0000_9998;
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #20;
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1", "halted", halted, 0);
        chk("R1", "freeze", freeze, 0);
        chk("R1", "fetch_en", fetch_en, 1);
        chk("R1", "insn_ready", insn_ready, 0);
        chk("R1", "core_insn_valid", core_insn_valid, 0);
        chk("R1", "cause_kind", cause_kind, 0);
        irq_req = 8'hFF;
        #1;
        chk("R1", "irq_to_core with zero mask", irq_to_core, 8'hFF);
        step();
        chk("R1", "no break with zero mask", halted, 0);
        irq_req = '0;

        // program comparators: 0..2 armed, 3 disarmed
        for (int i = 0; i < 4; i++) begin
            bp_wr_en = 1'b1;
            bp_wr_idx = 2'(i);
            bp_wr_addr = bp_addr(i);
            bp_wr_arm = (i != 3);
            step();
        end
        bp_wr_en = 1'b0;

        // table walk: R2 R3 R4 R6
        for (int v = 0; v < NV; v++) begin
            den_wr_en = 1'b1;
            den_wr_data = VEC[v].den;
            step();
            den_wr_en = 1'b0;
            ext_stop = VEC[v].ext;
            irq_req = VEC[v].irq;
            fetch_valid = 1'b1;
            fetch_addr = bp_addr(int'(VEC[v].sel));
            #1;
            chk("R3", $sformatf("v%0d irq_to_core", v), irq_to_core, VEC[v].irq & ~VEC[v].den);
            step();
            chk("R2", $sformatf("v%0d halted", v), halted, VEC[v].halt);
            chk("R5", $sformatf("v%0d freeze", v), freeze, VEC[v].halt);
            chk("R5", $sformatf("v%0d fetch_en", v), fetch_en, !VEC[v].halt);
            chk("R6", $sformatf("v%0d cause_kind", v), cause_kind, VEC[v].kind);
            chk("R6", $sformatf("v%0d cause_idx", v), cause_idx, VEC[v].idx);
            ext_stop = 1'b0;
            irq_req = '0;
            fetch_valid = 1'b0;
            if (halted) begin
                resume = 1'b1;
                step();
                resume = 1'b0;
                chk("R9", $sformatf("v%0d resumed", v), halted, 0);
            end
        end

        // R2 fetch_valid low gives no break
        fetch_addr = bp_addr(0);
        fetch_valid = 1'b0;
        step();
        chk("R2", "invalid fetch no break", halted, 0);

        // halt on comparator 0, then sources while halted are ignored
        fetch_valid = 1'b1;
        step();
        fetch_valid = 1'b0;
        chk("R2", "bp0 halted", halted, 1);
        ext_stop = 1'b1;
        irq_req = 8'h01;
        fetch_valid = 1'b1;
        fetch_addr = bp_addr(2);
        #1;
        chk("R3", "irq_to_core while halted", irq_to_core, 0);
        for (int c = 0; c < 3; c++) begin
            step();
            chk("R5", "freeze held", freeze, 1);
            chk("R7", "cause kind held", cause_kind, 1);
            chk("R7", "cause idx held", cause_idx, 0);
        end
        ext_stop = 1'b0;
        irq_req = '0;
        fetch_valid = 1'b0;

        // R8 injection handshake
        chk("R8", "ready when empty", insn_ready, 1);
        insn_valid = 1'b1;
        insn_data = 32'hA5A5_0001;
        step();
        insn_valid = 1'b0;
        chk("R8", "ready when full", insn_ready, 0);
        chk("R8", "core valid", core_insn_valid, 1);
        chk("R8", "core data", core_insn_data, 32'hA5A5_0001);
        step();
        chk("R8", "held without ready", core_insn_valid, 1);
        chk("R8", "data held", core_insn_data, 32'hA5A5_0001);
        core_insn_ready = 1'b1;
        step();
        core_insn_ready = 1'b0;
        chk("R8", "issued once", core_insn_valid, 0);
        chk("R8", "empty again", insn_ready, 1);

        // R9 resume together with core handshake
        insn_valid = 1'b1;
        insn_data = 32'h0000_0077;
        step();
        insn_valid = 1'b0;
        core_insn_ready = 1'b1;
        resume = 1'b1;
        #1;
        chk("R9", "word visible in resume cycle", core_insn_valid, 1);
        step();
        core_insn_ready = 1'b0;
        resume = 1'b0;
        chk("R9", "running after resume", halted, 0);
        chk("R9", "freeze low", freeze, 0);
        chk("R9", "fetch_en high", fetch_en, 1);
        chk("R9", "cause cleared", cause_kind, 0);
        chk("R9", "no word after resume", core_insn_valid, 0);

        // R9 pending word flushed on resume
        ext_stop = 1'b1;
        step();
        ext_stop = 1'b0;
        chk("R4", "ext halt", cause_kind, 3);
        insn_valid = 1'b1;
        insn_data = 32'hDEAD_0002;
        step();
        insn_valid = 1'b0;
        resume = 1'b1;
        step();
        resume = 1'b0;
        ext_stop = 1'b1;
        step();
        ext_stop = 1'b0;
        chk("R9", "flushed word absent", core_insn_valid, 0);
        chk("R9", "ready after flush", insn_ready, 1);
        resume = 1'b1;
        step();
        resume = 1'b0;

        // R10 resume while running
        resume = 1'b1;
        step();
        resume = 1'b0;
        chk("R10", "still running", halted, 0);
        chk("R10", "fetch_en", fetch_en, 1);
        chk("R10", "cause", cause_kind, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule